// File: doc/BRIEF.md
# Two-Channel DMA Control and Status Register File

This block holds the software-visible control state of a two-channel scatter-gather DMA. A 32-bit memory-mapped port reaches both channels. Each channel owns a window of 48 bytes. Inside that window sit a control word, a status word, a current-descriptor pointer, a tail-descriptor pointer, and eight general storage words.

The block drives run and soft-reset levels, and both descriptor pointers, out to the channel engines. When software writes the transmit channel's tail pointer, the block sends that engine a one-cycle start pulse. The engines report back through set-only event inputs: halted, idle, three interrupt flags, and a pointer advance that loads the current-descriptor register. Software clears the interrupt flags by writing ones to them.

A soft reset holds its control bit set until software reads the control word once. This gives software a way to see that a reset was requested before the channel can be restarted.

Top module: `dma_csr_top`

## Requirements
- R1: After the asynchronous reset, the control word of each channel reads 0x00010002 and its status word reads 0x00000001. Both pointers read 0, and `run_o` and `soft_rst_o` are 0.
- R2: An access at byte address A selects channel (A / 48) mod 2 and register word ((A mod 48) / 4). Channel 0 is at 0x00 and channel 1 is at 0x30, and 0x60 aliases onto channel 0.
- R3: A write to control (word 0) stores the written value with bit 1 forced to 1. Bit 0 of the control word drives that channel's `run_o`.
- R4: A control write whose bit 2 is 1, or any control write while the stored bit 2 is still 1, sets control to 0x00010006. The same write sets status to 0x00000001, clearing idle and flags 14:12, and raises `soft_rst_o`.
- R5: Stored control bit 2 clears only through a read of the control word. That read returns the word with bit 2 still set, and later reads show it cleared. `run_o` is never 1 while `soft_rst_o` is 1.
- R6: A control write with bit 0 = 1 and no reset in effect clears status bit 0 (halted) and status bit 1 (idle).
- R7: A write to the tail pointer (word 4) stores it and clears idle. Only on channel 0, `kick_o` pulses high for exactly the cycle after the write. The tail pointer changes only on such writes.
- R8: The engine event inputs set status bit 0, bit 1 and flags 14:12 respectively. An event wins over a same-cycle bus write that would clear the bit. A soft-reset write wins over every event.
- R9: Writing status (word 1) clears each of flags 14:12 whose written bit is 1. All other written status bits are ignored.
- R10: The current pointer (word 2) can be written over the bus. When `desc_adv_i` is high, the pointer loads `desc_next_i` in the next cycle, and this takes priority over a bus write in the same cycle.
- R11: Words 3 and 5 to 11 of each channel are plain read/write storage, separate for each channel.
- R12: A read returns its data on `rdata_o` the cycle after the request, and `rdata_o` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| halt_set_i | input | 2 | Per channel: set halted |
| idle_set_i | input | 2 | Per channel: set idle |
| flag_set_i | input | 6 | Channel c sets flags with bits [3c+2:3c] |
| desc_adv_i | input | 2 | Per channel: load current pointer |
| desc_next_i | input | 64 | Channel c next pointer in bits [32c+31:32c] |
| run_o | output | 2 | Per channel run level |
| soft_rst_o | output | 2 | Per channel soft reset pending |
| cur_desc_o | output | 64 | Current pointers, channel c in [32c+31:32c] |
| tail_desc_o | output | 64 | Tail pointers, same layout |
| kick_o | output | 1 | Start pulse to the channel 0 engine |

## Verification
The control word is driven with a plain run value, with a reset-and-run value, and with a run value while a reset is still pending. These three cases separate forcing bit 1, holding the reset bit, and gating the run output. Status is written both with and without same-cycle engine events, which shows whether write-one-to-clear or the set event takes priority. Accesses at 0x0C, 0x3C and 0x6C show that aliasing falls on channel 0 and that channel 1's storage is separate. Tail-pointer writes on each channel show that the start pulse comes from channel 0 only.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned NCH       = 2;
  localparam int unsigned WIN_BYTES = 48;
  localparam int unsigned NFLAG     = 3;
  localparam int unsigned STORE_N   = 8;
  localparam int unsigned FLAG_LSB  = 12;

  localparam logic [3:0] W_CTRL = 4'd0;
  localparam logic [3:0] W_STAT = 4'd1;
  localparam logic [3:0] W_CUR  = 4'd2;
  localparam logic [3:0] W_TAIL = 4'd4;

  localparam int unsigned C_RUN  = 0;
  localparam int unsigned C_TMOD = 1;
  localparam int unsigned C_SRST = 2;

  localparam logic [DW-1:0] CTRL_POR  = 32'h0001_0002;
  localparam logic [DW-1:0] CTRL_SRST = 32'h0001_0006;
endpackage

// File: rtl/dma_csr_dec.sv
module dma_csr_dec import dma_csr_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ch_o,
  output logic [3:0]        widx_o
);
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);

  logic [ADDR_W-1:0] quo, rem;

  always_comb begin
    quo    = addr_i / WIN;
    rem    = addr_i - quo * WIN;
    ch_o   = quo[0];
    widx_o = rem[5:2];
  end
endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan import dma_csr_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [3:0]       widx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             halt_set_i,
  input  logic             idle_set_i,
  input  logic [NFLAG-1:0] flag_set_i,
  input  logic             adv_i,
  input  logic [DW-1:0]    adv_ptr_i,
  output logic [DW-1:0]    rword_o,
  output logic             run_o,
  output logic             srst_o,
  output logic [DW-1:0]    cur_o,
  output logic [DW-1:0]    tail_o
);
  logic [DW-1:0]    ctrl_q, cur_q, tail_q;
  logic             halt_q, idle_q, halt_d, idle_d;
  logic [NFLAG-1:0] flag_q, flag_d;
  logic [DW-1:0]    store_q [STORE_N];

  logic wr_ctrl, wr_stat, wr_cur, wr_tail, wr_store, rd_ctrl, srst_wr;
  logic [DW-1:0] ctrl_wv;
  logic [2:0]    slot;

  always_comb begin
    wr_ctrl  = wr_i && widx_i == W_CTRL;
    wr_stat  = wr_i && widx_i == W_STAT;
    wr_cur   = wr_i && widx_i == W_CUR;
    wr_tail  = wr_i && widx_i == W_TAIL;
    wr_store = wr_i && (widx_i == 4'd3 || (widx_i >= 4'd5 && widx_i <= 4'd11));
    rd_ctrl  = rd_i && widx_i == W_CTRL;
    slot     = (widx_i == 4'd3) ? 3'd0 : 3'(widx_i - 4'd4);
    ctrl_wv  = wdata_i;
    ctrl_wv[C_TMOD] = 1'b1;
    ctrl_wv[C_SRST] = wdata_i[C_SRST] | ctrl_q[C_SRST];
    srst_wr  = wr_ctrl && ctrl_wv[C_SRST];
  end

  // soft reset beats engine events; engine events beat bus clears
  always_comb begin
    halt_d = halt_q;
    idle_d = idle_q;
    flag_d = flag_q;
    if (srst_wr) begin
      halt_d = 1'b1;
      idle_d = 1'b0;
      flag_d = '0;
    end else begin
      if (wr_ctrl && ctrl_wv[C_RUN]) begin
        halt_d = 1'b0;
        idle_d = 1'b0;
      end
      if (wr_tail) idle_d = 1'b0;
      if (wr_stat) flag_d = flag_q & ~wdata_i[FLAG_LSB +: NFLAG];
      halt_d = halt_d | halt_set_i;
      idle_d = idle_d | idle_set_i;
      flag_d = flag_d | flag_set_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_POR;
      halt_q <= 1'b1;
      idle_q <= 1'b0;
      flag_q <= '0;
      cur_q  <= '0;
      tail_q <= '0;
      for (int i = 0; i < STORE_N; i++) store_q[i] <= '0;
    end else begin
      halt_q <= halt_d;
      idle_q <= idle_d;
      flag_q <= flag_d;
      if (wr_ctrl)      ctrl_q <= srst_wr ? CTRL_SRST : ctrl_wv;
      else if (rd_ctrl) ctrl_q[C_SRST] <= 1'b0;
      if (adv_i)        cur_q <= adv_ptr_i;
      else if (wr_cur)  cur_q <= wdata_i;
      if (wr_tail)      tail_q <= wdata_i;
      if (wr_store)     store_q[slot] <= wdata_i;
    end
  end

  always_comb begin
    case (widx_i)
      W_CTRL:  rword_o = ctrl_q;
      W_STAT:  rword_o = {{(DW-FLAG_LSB-NFLAG){1'b0}}, flag_q, {(FLAG_LSB-2){1'b0}}, idle_q, halt_q};
      W_CUR:   rword_o = cur_q;
      W_TAIL:  rword_o = tail_q;
      default: rword_o = store_q[slot];
    endcase
  end

  assign run_o  = ctrl_q[C_RUN];
  assign srst_o = ctrl_q[C_SRST];
  assign cur_o  = cur_q;
  assign tail_o = tail_q;
endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top import dma_csr_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NCH-1:0]       halt_set_i,
  input  logic [NCH-1:0]       idle_set_i,
  input  logic [NCH*NFLAG-1:0] flag_set_i,
  input  logic [NCH-1:0]       desc_adv_i,
  input  logic [NCH*DW-1:0]    desc_next_i,
  output logic [NCH-1:0]       run_o,
  output logic [NCH-1:0]       soft_rst_o,
  output logic [NCH*DW-1:0]    cur_desc_o,
  output logic [NCH*DW-1:0]    tail_desc_o,
  output logic                 kick_o
);
  logic          ch;
  logic [3:0]    widx;
  logic [DW-1:0] rword [NCH];
  logic [DW-1:0] rdata_q;
  logic          kick_q;

  dma_csr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .ch_o   (ch),
    .widx_o (widx)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = (ch == 1'(c));
    dma_csr_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (req_i && we_i && sel),
      .rd_i       (req_i && !we_i && sel),
      .widx_i     (widx),
      .wdata_i    (wdata_i),
      .halt_set_i (halt_set_i[c]),
      .idle_set_i (idle_set_i[c]),
      .flag_set_i (flag_set_i[c*NFLAG +: NFLAG]),
      .adv_i      (desc_adv_i[c]),
      .adv_ptr_i  (desc_next_i[c*DW +: DW]),
      .rword_o    (rword[c]),
      .run_o      (run_o[c]),
      .srst_o     (soft_rst_o[c]),
      .cur_o      (cur_desc_o[c*DW +: DW]),
      .tail_o     (tail_desc_o[c*DW +: DW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      kick_q  <= 1'b0;
    end else begin
      if (req_i && !we_i) rdata_q <= rword[ch];
      kick_q <= req_i && we_i && !ch && widx == W_TAIL;
    end
  end

  assign rdata_o = rdata_q;
  assign kick_o  = kick_q;
endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk import dma_csr_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DW-1:0]        wdata_i,
  input logic [NCH-1:0]       desc_adv_i,
  input logic [NCH*DW-1:0]    desc_next_i,
  input logic [NCH-1:0]       run_o,
  input logic [NCH-1:0]       soft_rst_o,
  input logic [NCH*DW-1:0]    cur_desc_o,
  input logic [NCH*DW-1:0]    tail_desc_o,
  input logic                 kick_o
);
  logic       ch;
  logic [3:0] widx;
  logic       tail0_wr, srst0_wr;

  dma_csr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr_i(addr_i), .ch_o(ch), .widx_o(widx));

  assign tail0_wr = req_i && we_i && !ch && widx == W_TAIL;
  assign srst0_wr = req_i && we_i && !ch && widx == W_CTRL && wdata_i[C_SRST];

  p_kick_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail0_wr |=> kick_o);
  p_kick_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |-> $past(tail0_wr));
  p_tail_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tail0_wr |=> $stable(tail_desc_o[DW-1:0]));
  p_srst_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst0_wr |=> soft_rst_o[0]);
  p_no_run_in_rst0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o[0] |-> !run_o[0]);
  p_no_run_in_rst1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o[1] |-> !run_o[1]);
  p_adv_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_adv_i[0] |=> cur_desc_o[DW-1:0] == $past(desc_next_i[DW-1:0]));
endmodule

bind dma_csr_top dma_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .desc_adv_i  (desc_adv_i),
  .desc_next_i (desc_next_i),
  .run_o       (run_o),
  .soft_rst_o  (soft_rst_o),
  .cur_desc_o  (cur_desc_o),
  .tail_desc_o (tail_desc_o),
  .kick_o      (kick_o)
);

// File: tb/tb_dma_csr_top.sv
`timescale 1ns/1ps
module tb_dma_csr_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [1:0]  hs = 0, is = 0, adv = 0;
  logic [5:0]  fs = 0;
  logic [63:0] nxt = 0;
  logic [1:0]  run, srst;
  logic [63:0] cur, tail;
  logic        kick;

  always #10 clk = ~clk;

  dma_csr_top #(.ADDR_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .halt_set_i(hs), .idle_set_i(is),
    .flag_set_i(fs), .desc_adv_i(adv), .desc_next_i(nxt), .run_o(run),
    .soft_rst_o(srst), .cur_desc_o(cur), .tail_desc_o(tail), .kick_o(kick)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  logic [31:0] m_ctrl [2], m_cur [2], m_tail [2];
  logic [31:0] m_st [2][12];
  bit          m_halt [2], m_idle [2];
  logic [2:0]  m_flag [2];
  logic [31:0] m_rd;
  bit          m_kick;

  function automatic logic [31:0] m_read(int c, int w);
    case (w)
      0: return m_ctrl[c];
      1: return {17'd0, m_flag[c], 10'd0, m_idle[c], m_halt[c]};
      2: return m_cur[c];
      4: return m_tail[c];
      default: return m_st[c][w];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_ctrl[c] = 32'h00010002; m_cur[c] = 0; m_tail[c] = 0;
        m_halt[c] = 1; m_idle[c] = 0; m_flag[c] = 0;
        for (int w = 0; w < 12; w++) m_st[c][w] = 0;
      end
      m_rd = 0; m_kick = 0;
    end else begin
      int ch, w;
      ch = (int'(addr) / 48) % 2;
      w  = (int'(addr) % 48) / 4;
      if (req && !we) m_rd = m_read(ch, w);
      m_kick = req && we && ch == 0 && w == 4;
      for (int c = 0; c < 2; c++) begin
        bit wr, sr;
        logic [31:0] v;
        wr = req && we && ch == c;
        sr = 0;
        if (wr && w == 0) begin
          v = wdata | 32'h2 | (m_ctrl[c] & 32'h4);
          if (v[2]) begin m_ctrl[c] = 32'h00010006; sr = 1; end
          else begin
            m_ctrl[c] = v;
            if (v[0]) begin m_halt[c] = 0; m_idle[c] = 0; end
          end
        end else if (req && !we && ch == c && w == 0) m_ctrl[c][2] = 0;
        if (wr && w == 1) m_flag[c] = m_flag[c] & ~wdata[14:12];
        if (wr && w == 4) begin m_tail[c] = wdata; m_idle[c] = 0; end
        if (adv[c]) m_cur[c] = nxt[c*32 +: 32];
        else if (wr && w == 2) m_cur[c] = wdata;
        if (wr && w != 0 && w != 1 && w != 2 && w != 4) m_st[c][w] = wdata;
        if (sr) begin m_halt[c] = 1; m_idle[c] = 0; m_flag[c] = 0; end
        else begin
          m_halt[c] = m_halt[c] | hs[c];
          m_idle[c] = m_idle[c] | is[c];
          m_flag[c] = m_flag[c] | fs[c*3 +: 3];
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(rdata, m_rd, "R12 rdata_o vs model");
    chk(kick, m_kick, "R7 kick_o vs model");
    for (int c = 0; c < 2; c++) begin
      chk(run[c], m_ctrl[c][0], "R3 run_o vs model");
      chk(srst[c], m_ctrl[c][2], "R5 soft_rst_o vs model");
      chk(cur[c*32 +: 32], m_cur[c], "R10 cur_desc_o vs model");
      chk(tail[c*32 +: 32], m_tail[c], "R7 tail_desc_o vs model");
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    chk(rdata, exp, tag);
  endtask

  task automatic report;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(run, 2'b00, "R1 run_o after reset");
    chk(srst, 2'b00, "R1 soft_rst_o after reset");
    rst_n = 1;
    rd_chk(8'h00, 32'h00010002, "R1 ch0 ctrl reset");
    rd_chk(8'h04, 32'h00000001, "R1 ch0 status reset");
    rd_chk(8'h30, 32'h00010002, "R1 ch1 ctrl reset");
    rd_chk(8'h34, 32'h00000001, "R1 ch1 status reset");
    rd_chk(8'h38, 32'h0, "R1 ch1 cur reset");
    // R3 / R6
    bus_wr(8'h00, 32'h00000001);
    chk(run[0], 1'b1, "R3 run_o set");
    rd_chk(8'h00, 32'h00000003, "R3 tail mode forced");
    rd_chk(8'h04, 32'h00000000, "R6 run clears halted");
    // R2 / R11
    bus_wr(8'h0C, 32'h0000A5A5);
    rd_chk(8'h6C, 32'h0000A5A5, "R2 alias 0x60 onto ch0");
    rd_chk(8'h3C, 32'h0, "R2 ch1 storage separate");
    bus_wr(8'h5C, 32'h00001234);
    rd_chk(8'h5C, 32'h00001234, "R11 ch1 word 11 storage");
    rd_chk(8'h2C, 32'h0, "R11 ch0 word 11 untouched");
    // R7
    @(negedge clk); is[0] = 1; @(negedge clk); is[0] = 0;
    rd_chk(8'h04, 32'h00000002, "R8 idle set event");
    bus_wr(8'h10, 32'h00000100);
    chk(kick, 1'b1, "R7 kick after ch0 tail write");
    @(negedge clk);
    chk(kick, 1'b0, "R7 kick single cycle");
    rd_chk(8'h04, 32'h00000000, "R7 tail write clears idle");
    bus_wr(8'h40, 32'h00000200);
    chk(kick, 1'b0, "R7 no kick from ch1");
    chk(tail[63:32], 32'h200, "R7 ch1 tail stored");
    // R8 / R9
    @(negedge clk); fs[2:0] = 3'b101; @(negedge clk); fs = 0;
    rd_chk(8'h04, 32'h00005000, "R8 flag set events");
    bus_wr(8'h04, 32'h00001003);
    rd_chk(8'h04, 32'h00004000, "R9 w1c and ignored bits");
    @(negedge clk); req = 1; we = 1; addr = 8'h04; wdata = 32'h00007000; fs[2:0] = 3'b001;
    @(negedge clk); req = 0; we = 0; fs = 0;
    rd_chk(8'h04, 32'h00001000, "R8 event beats w1c");
    @(negedge clk); req = 1; we = 1; addr = 8'h00; wdata = 32'h1; hs[0] = 1;
    @(negedge clk); req = 0; we = 0; hs = 0;
    rd_chk(8'h04, 32'h00001001, "R8 halt event beats run write");
    // R10
    @(negedge clk); req = 1; we = 1; addr = 8'h08; wdata = 32'h1; adv[0] = 1; nxt[31:0] = 32'h000DEAD0;
    @(negedge clk); req = 0; we = 0; adv = 0;
    chk(cur[31:0], 32'h000DEAD0, "R10 advance beats bus write");
    bus_wr(8'h38, 32'h00000080);
    rd_chk(8'h38, 32'h00000080, "R10 ch1 cur bus write");
    // R4 / R5
    bus_wr(8'h00, 32'h00000005);
    chk(srst[0], 1'b1, "R4 soft reset raised");
    chk(run[0], 1'b0, "R5 run gated in reset");
    rd_chk(8'h04, 32'h00000001, "R4 status after soft reset");
    bus_wr(8'h00, 32'h00000001);
    chk(run[0], 1'b0, "R5 run write ignored while pending");
    rd_chk(8'h00, 32'h00010006, "R5 first read shows reset");
    chk(srst[0], 1'b0, "R5 read clears reset bit");
    rd_chk(8'h00, 32'h00010002, "R5 second read cleared");
    bus_wr(8'h00, 32'h00000001);
    chk(run[0], 1'b1, "R6 run after reset cleared");
    rd_chk(8'h04, 32'h00000000, "R6 halted cleared after restart");
    repeat (3) @(negedge clk);
    report();
  end
endmodule